// File: doc/BRIEF.md
# Backpressure Training Request Detector

This block watches a backpressure line that arrives with no timing relation to the local clock. The far-side receiver raises that line to keep its flow-control FIFO from overflowing. The block resynchronizes the line and always forwards the clean level as a transmit-pause indication, so the local flow-control transmitter stops whenever the far side asks it to.

A backpressure line normally means only "pause". This block can also read a long, unbroken high level on that line as a command. When the request enable is set and the synchronized level stays high for a set number of consecutive clock cycles (32 by default), the block emits a single-cycle training request. The flow-control transmitter takes that request as an order to send a de-skew training sequence. A sticky flag records that a request has fired, and stays set until software clears it.

Top module: `bp_train_detect`

## Requirements
- R1: While reset is active, and in the first cycle after it is released, `pause_o`, `train_req_o` and `train_seen_o` are all low.
- R2: `pause_o` equals the value that `bp_async_i` had SYNC_STAGES rising clock edges earlier (two by default).
- R3: `pause_o` follows the backpressure level whatever the value of `train_en_i`.
- R4: Suppose the synchronized level (the value that `pause_o` shows) is first sampled high at edge t and then stays high. If `train_en_i` is 1 at edge t+RUN_LEN-1, `train_req_o` is 1 for exactly the one cycle that follows that edge. Counted from the input, this is the cycle after edge s+SYNC_STAGES+RUN_LEN-1, where s is the first edge that sees `bp_async_i` high.
- R5: A continuous high run gives at most one request, however long the run lasts.
- R6: Any low synchronized sample restarts the count. A run shorter than RUN_LEN samples gives no request, and a new request needs a fresh run of a full RUN_LEN samples.
- R7: `train_en_i` is read only at the edge where a run reaches RUN_LEN. If it is 0 at that edge, that run gives no request, even if enable is raised later in the same run.
- R8: `train_seen_o` rises together with `train_req_o` and stays high until `seen_clr_i` is 1 at an edge where no request fires. If a request fires at the same edge as a clear, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bp_async_i | input | 1 | Backpressure level from the far side, asynchronous to `clk` |
| train_en_i | input | 1 | 1 lets a long backpressure run be read as a training request |
| seen_clr_i | input | 1 | Clears the sticky request flag |
| pause_o | output | 1 | Synchronized backpressure level; pauses the transmitter |
| train_req_o | output | 1 | One-cycle de-skew training request |
| train_seen_o | output | 1 | Sticky flag: a training request has fired |

## Verification
The bench builds the block with RUN_LEN = 5 and SYNC_STAGES = 2. With those values, every 11-bit backpressure pattern can be streamed back to back in a few tens of thousands of cycles. That set holds runs below, exactly at, and well beyond the threshold, and many runs that cross the boundary between two patterns. Half of the patterns run with enable tied high. The other half toggle enable every cycle, so the enable value at the exact threshold edge varies. A periodic clear lands both on quiet cycles and on cycles where a request fires. The bench predicts every output arithmetically from the run length of the input it drove.

// File: rtl/bp_train_pkg.sv
package bp_train_pkg;

  // Counter width able to hold the values 0..limit inclusive.
  function automatic int unsigned run_cnt_width(input int unsigned limit);
    return (limit < 1) ? 1 : $clog2(limit + 1);
  endfunction

endpackage

// File: rtl/bp_rst_sync.sv
module bp_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sn = chain_q[STAGES-1];
endmodule

// File: rtl/bp_level_sync.sv
module bp_level_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_sn,
  input  logic async_i,
  output logic level_o
);
  logic [STAGES-1:0] stage_q;
  logic [STAGES-1:0] stage_d;

  generate
    genvar gi;
    for (gi = 0; gi < STAGES; gi++) begin : g_stage
      if (gi == 0) begin : g_first
        always_comb stage_d[gi] = async_i;
      end else begin : g_next
        always_comb stage_d[gi] = stage_q[gi-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) stage_q <= '0;
    else         stage_q <= stage_d;
  end

  assign level_o = stage_q[STAGES-1];
endmodule

// File: rtl/bp_run_detect.sv
module bp_run_detect
  import bp_train_pkg::*;
#(
  parameter int unsigned RUN_LEN = 32
) (
  input  logic clk,
  input  logic rst_sn,
  input  logic level_i,
  input  logic en_i,
  output logic fire_o,
  output logic req_o
);
  localparam int unsigned CW = run_cnt_width(RUN_LEN);
  localparam logic [CW-1:0] CNT_TOP = CW'(RUN_LEN);
  localparam logic [CW-1:0] CNT_HIT = CW'(RUN_LEN - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_ce;
  logic          hit;
  logic          req_q, req_d;

  // Next-state logic: clear on any low sample, saturate at the top.
  always_comb begin
    hit    = level_i && (cnt_q == CNT_HIT);
    cnt_ce = !level_i || (cnt_q != CNT_TOP);
    cnt_d  = level_i ? cnt_q + 1'b1 : '0;
    req_d  = hit && en_i;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      cnt_q <= '0;
      req_q <= 1'b0;
    end else begin
      if (cnt_ce) cnt_q <= cnt_d;
      req_q <= req_d;
    end
  end

  assign fire_o = req_d;
  assign req_o  = req_q;

  assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_sn)
    cnt_q <= CNT_TOP);
  assert_req_single_R5: assert property (@(posedge clk) disable iff (!rst_sn)
    req_q |=> !req_q);
  assert_req_at_top_R4: assert property (@(posedge clk) disable iff (!rst_sn)
    req_q |-> (cnt_q == CNT_TOP));
  assert_req_needs_en_R7: assert property (@(posedge clk) disable iff (!rst_sn)
    req_q |-> $past(en_i));
  assert_low_restarts_R6: assert property (@(posedge clk) disable iff (!rst_sn)
    !level_i |=> (cnt_q == '0));
endmodule

// File: rtl/bp_sticky_flag.sv
module bp_sticky_flag (
  input  logic clk,
  input  logic rst_sn,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q, flag_d, flag_ce;

  always_comb begin
    flag_ce = set_i || clr_i;
    flag_d  = set_i;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn)      flag_q <= 1'b0;
    else if (flag_ce) flag_q <= flag_d;
  end

  assign flag_o = flag_q;

  assert_flag_set_R8: assert property (@(posedge clk) disable iff (!rst_sn)
    set_i |=> flag_q);
  assert_flag_clear_cause_R8: assert property (@(posedge clk) disable iff (!rst_sn)
    $fell(flag_q) |-> $past(clr_i));
endmodule

// File: rtl/bp_train_detect.sv
module bp_train_detect #(
  parameter int unsigned RUN_LEN     = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bp_async_i,
  input  logic train_en_i,
  input  logic seen_clr_i,
  output logic pause_o,
  output logic train_req_o,
  output logic train_seen_o
);
  logic rst_sn;
  logic level;
  logic fire;

  bp_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  bp_level_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_sn  (rst_sn),
    .async_i (bp_async_i),
    .level_o (level)
  );

  bp_run_detect #(.RUN_LEN(RUN_LEN)) u_run (
    .clk     (clk),
    .rst_sn  (rst_sn),
    .level_i (level),
    .en_i    (train_en_i),
    .fire_o  (fire),
    .req_o   (train_req_o)
  );

  bp_sticky_flag u_seen (
    .clk    (clk),
    .rst_sn (rst_sn),
    .set_i  (fire),
    .clr_i  (seen_clr_i),
    .flag_o (train_seen_o)
  );

  assign pause_o = level;

  assert_req_with_flag_R8: assert property (@(posedge clk) disable iff (!rst_sn)
    train_req_o |-> train_seen_o);
endmodule

// File: tb/tb_bp_train_detect.sv
module tb_bp_train_detect;
  localparam int unsigned RUN   = 5;
  localparam int unsigned SYNC  = 2;
  localparam int unsigned SATV  = RUN + 1;

  logic clk = 1'b0;
  logic rst_n;
  logic bp_in, en_in, clr_in;
  logic pause_o, train_req_o, train_seen_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  int unsigned in_hist [0:SYNC];
  int unsigned rl_hist [0:SYNC];
  logic        exp_seen;

  bp_train_detect #(.RUN_LEN(RUN), .SYNC_STAGES(SYNC)) dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .bp_async_i   (bp_in),
    .train_en_i   (en_in),
    .seen_clr_i   (clr_in),
    .pause_o      (pause_o),
    .train_req_o  (train_req_o),
    .train_seen_o (train_seen_o)
  );

  always #10 clk = ~clk;

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s cycle %0d: actual %b expected %b", tag, cyc, act, exp);
    end
  endtask

  // One clock: drive inputs, let an edge pass, update the model, compare.
  task automatic step(input logic b, input logic e, input logic c);
    logic exp_pause, exp_req;
    string rtag;
    bp_in = b; en_in = e; clr_in = c;
    @(posedge clk);
    cyc++;
    for (int k = SYNC; k > 0; k--) begin
      in_hist[k] = in_hist[k-1];
      rl_hist[k] = rl_hist[k-1];
    end
    in_hist[0] = b;
    rl_hist[0] = b ? ((rl_hist[1] >= SATV) ? SATV : rl_hist[1] + 1) : 0;
    exp_pause = in_hist[SYNC-1][0];
    exp_req   = e && (rl_hist[SYNC] == RUN);
    if (exp_req)     exp_seen = 1'b1;
    else if (c)      exp_seen = 1'b0;
    if (exp_req)                   rtag = "R4";
    else if (!e)                   rtag = "R7";
    else if (rl_hist[SYNC] > RUN)  rtag = "R5";
    else                           rtag = "R6";
    @(negedge clk);
    check(e ? "R2" : "R3", pause_o, exp_pause);
    check(rtag, train_req_o, exp_req);
    check("R8", train_seen_o, exp_seen);
  endtask

  initial begin
    #3000000;
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bp_in = 1'b0; en_in = 1'b1; clr_in = 1'b0;
    exp_seen = 1'b0;
    for (int k = 0; k <= SYNC; k++) begin
      in_hist[k] = 0;
      rl_hist[k] = 0;
    end
    repeat (3) @(negedge clk);
    check("R1", pause_o, 1'b0);
    check("R1", train_req_o, 1'b0);
    check("R1", train_seen_o, 1'b0);
    rst_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R1", pause_o, 1'b0);
    check("R1", train_req_o, 1'b0);
    check("R1", train_seen_o, 1'b0);
    repeat (3) @(negedge clk);

    for (int p = 0; p < 4096; p++) begin
      for (int b = 0; b < 11; b++) begin
        logic en_v;
        en_v = p[11] ? logic'(b % 2) : 1'b1;
        step(p[b], en_v, ((cyc % 13) == 0));
      end
    end
    // Long run past the threshold, then a clear with no request.
    for (int i = 0; i < 3 * RUN; i++) step(1'b1, 1'b1, 1'b0);
    step(1'b0, 1'b1, 1'b1);
    for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule